// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is a single DMA channel that moves 32-bit words between a fixed peripheral-side address and an incrementing memory-side address. Software programs two pointer registers, two sequence registers and a control word, then sets the enable bit. The channel issues one word transfer per cycle on a simple valid/ready handshake. Transfers are paced by one of up to 31 peripheral request lines, or run freely when flow control is off.

Two run modes exist. In one-shot mode the channel moves the programmed count of words, raises its end-of-count flag and goes idle. In continuous mode with the double-buffer bit set, the programmed count describes half of a buffer. The channel raises end-of-count after every half and flips a ping-pong flag. At the end of the second half it reloads both pointers, so new pointers written during a run take effect at the next buffer boundary. The channel can be parked without disabling it by selecting request source 31, which never grants a transfer. It can also be parked with the hold bit.

A word-addressed register port gives access to the state. Offset 0 is control, 1 is status, 2 is the memory pointer, 3 the memory sequence word, 4 the peripheral pointer and 5 the peripheral sequence word. Reads are combinational.

Top module: `pdma_channel`

## Requirements
- R1: After reset the control and status words read zero, `irq` is low and `xfer_valid` is low.
- R2: `xfer_valid` is high only while the channel is busy, enable (control bit 31) is set, hold (bit 29) is clear and request select (bits 20:16) is not 31. When flow control (bit 21) is set, the request line chosen by request select must also be high. When flow control is clear, the request lines are ignored.
- R3: In one-shot mode (control bit 27 set) a run moves word count (bits 15:2) plus one words. The memory address starts at the memory pointer and steps by 4 per word. The peripheral address stays at the peripheral pointer. After the last word, busy (status bit 31) clears, end-of-count pending (status bit 30) sets and no more transfers are issued.
- R4: The remaining count (status bits 15:2) loads the word count when a run starts. It drops by one for each transferred word and reloads the word count when a count completes.
- R5: In continuous mode (bit 27 clear) with the double-buffer bit (memory sequence bit 19) set, each completed half sets pending and flips ping-pong (status bit 28, 1 after the first half). The memory address carries on across the halves, and both pointers reload from the registers after the second half. With the double-buffer bit clear, every completed count reloads the pointers and ping-pong stays 0.
- R6: Writing the status word with bit 30 set clears pending, and writing it with bit 30 clear leaves pending unchanged. A count that completes in the same cycle as the clear wins, so pending stays set.
- R7: `irq` equals pending AND interrupt enable (control bit 30).
- R8: With request select 31 or hold set, a busy channel issues no transfers, keeps its remaining count and shows halted (status bit 29). Selecting a valid source again resumes the run where it stopped.
- R9: Writing the control word with enable clear stops the channel at once: busy clears and no transfer is issued.
- R10: `xfer_dir` follows control bit 28: 1 means memory to peripheral, 0 means peripheral to memory.
- R11: The pointer registers read back with bits 1:0 forced to zero. The sequence registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | NREQ | Peripheral request lines |
| xfer_ready | input | 1 | Bus accepts the offered word this cycle |
| xfer_valid | output | 1 | A word transfer is offered |
| xfer_dir | output | 1 | 1: memory to peripheral, 0: peripheral to memory |
| xfer_mem_addr | output | AW | Memory-side word address |
| xfer_per_addr | output | AW | Peripheral-side address |
| irq | output | 1 | End-of-count interrupt |

## Verification
A wrong remaining count or address register shows up at `xfer_mem_addr` on the very next accepted word, or as a run that ends one word early or late. The bench catches this by counting accepted words against the programmed count. A wrong ping-pong or pending bit shows in the status word and on `irq` in the cycle after the half that should have set it. A pointer reload taken at the wrong boundary shows as a jump in the memory address on the first word of the following half. Gating faults appear as `xfer_valid` disagreeing with the randomly driven request line in the same cycle.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    // width of the word-count field in the control and status words
    localparam int CNT_W = 14;
    localparam int PAD_W = 26 - CNT_W;

    // request-select code that never grants a transfer
    localparam logic [4:0] RSEL_OFF = 5'd31;

    // bit of the memory sequence word that selects double buffering
    localparam int DBL_BIT = 19;

    // register word offsets
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_MPTR = 3'd2;
    localparam logic [2:0] A_MSEQ = 3'd3;
    localparam logic [2:0] A_PPTR = 3'd4;
    localparam logic [2:0] A_PSEQ = 3'd5;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             hold;
        logic             dir;
        logic             once;
        logic             flow;
        logic [4:0]       rsel;
        logic [CNT_W-1:0] wcnt;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(logic [31:0] w);
        ctrl_t c;
        c.en   = w[31];
        c.ie   = w[30];
        c.hold = w[29];
        c.dir  = w[28];
        c.once = w[27];
        c.flow = w[21];
        c.rsel = w[20:16];
        c.wcnt = w[2 +: CNT_W];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[31] = c.en;
        w[30] = c.ie;
        w[29] = c.hold;
        w[28] = c.dir;
        w[27] = c.once;
        w[21] = c.flow;
        w[20:16] = c.rsel;
        w[2 +: CNT_W] = c.wcnt;
        return w;
    endfunction

endpackage

// File: rtl/pdma_regfile.sv
module pdma_regfile
    import pdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output ctrl_t         ctrl,
    output logic [AW-1:0] mptr,
    output logic [AW-1:0] pptr,
    output logic [31:0]   mseq,
    output logic [31:0]   pseq
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [AW-1:0] mptr;
        logic [AW-1:0] pptr;
        logic [31:0]   mseq;
        logic [31:0]   pseq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                A_CTRL:  r_d.ctrl = unpack_ctrl(wdata);
                A_MPTR:  r_d.mptr = {wdata[AW-1:2], 2'b00};
                A_MSEQ:  r_d.mseq = wdata;
                A_PPTR:  r_d.pptr = {wdata[AW-1:2], 2'b00};
                A_PSEQ:  r_d.pseq = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl = r_q.ctrl;
    assign mptr = r_q.mptr;
    assign pptr = r_q.pptr;
    assign mseq = r_q.mseq;
    assign pseq = r_q.pseq;

    // R11
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_MPTR) |=> (r_q.mptr[1:0] == 2'b00));

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREQ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            cfg,
    input  logic             dbl,
    input  logic [AW-1:0]    mptr,
    input  logic [AW-1:0]    pptr,
    input  logic             ctrl_wr,
    input  logic             new_en,
    input  logic [CNT_W-1:0] new_wcnt,
    input  logic             stat_wr,
    input  logic             stat_clr,
    input  logic [NREQ-1:0]  dreq,
    input  logic             xfer_ready,
    output logic             xfer_valid,
    output logic             xfer_dir,
    output logic [AW-1:0]    xfer_mem_addr,
    output logic [AW-1:0]    xfer_per_addr,
    output logic             busy,
    output logic             pend,
    output logic             halted,
    output logic             ping,
    output logic [CNT_W-1:0] remain,
    output logic             irq
);

    localparam logic [AW-1:0] ADDR_STEP = AW'(4);

    typedef struct packed {
        logic             busy;
        logic             pend;
        logic             ping;
        logic [CNT_W-1:0] remain;
        logic [AW-1:0]    maddr;
        logic [AW-1:0]    paddr;
    } st_t;

    st_t  st_d, st_q;
    logic line, go, fire, last;

    always_comb begin
        line = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (cfg.rsel == 5'(i)) line = dreq[i];
        end
        go   = st_q.busy && cfg.en && !cfg.hold && (cfg.rsel != RSEL_OFF)
               && (!cfg.flow || line);
        fire = go && xfer_ready;
        last = fire && (st_q.remain == '0);

        st_d = st_q;
        if (fire) begin
            if (last) begin
                st_d.pend   = 1'b1;
                st_d.remain = cfg.wcnt;
                if (cfg.once) begin
                    st_d.busy = 1'b0;
                end else if (dbl && !st_q.ping) begin
                    st_d.ping  = 1'b1;
                    st_d.maddr = st_q.maddr + ADDR_STEP;
                end else begin
                    st_d.ping  = 1'b0;
                    st_d.maddr = mptr;
                    st_d.paddr = pptr;
                end
            end else begin
                st_d.remain = st_q.remain - 1'b1;
                st_d.maddr  = st_q.maddr + ADDR_STEP;
            end
        end

        if (stat_wr && stat_clr && !last) st_d.pend = 1'b0;

        if (ctrl_wr) begin
            if (!new_en) begin
                st_d.busy = 1'b0;
            end else if (!st_q.busy) begin
                st_d.busy   = 1'b1;
                st_d.remain = new_wcnt;
                st_d.ping   = 1'b0;
                st_d.maddr  = mptr;
                st_d.paddr  = pptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_valid    = go;
    assign xfer_dir      = cfg.dir;
    assign xfer_mem_addr = st_q.maddr;
    assign xfer_per_addr = st_q.paddr;
    assign busy          = st_q.busy;
    assign pend          = st_q.pend;
    assign ping          = st_q.ping;
    assign remain        = st_q.remain;
    assign halted        = st_q.busy && (cfg.hold || cfg.rsel == RSEL_OFF);
    assign irq           = st_q.pend && cfg.ie;

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.remain != '0) |=> (st_q.remain == $past(st_q.remain) - 1'b1));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last) |=> (st_q.maddr == $past(st_q.maddr) + ADDR_STEP));

    // R3
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cfg.once) |=> (!st_q.busy && st_q.pend));

    // R5
    ping_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !cfg.once && dbl) |=> (st_q.ping != $past(st_q.ping)));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_clr && !last) |=> !st_q.pend);

    // R8
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && cfg.rsel == RSEL_OFF && !ctrl_wr) |=> (st_q.remain == $past(st_q.remain)));

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NREQ-1:0] dreq,
    input  logic            xfer_ready,
    output logic            xfer_valid,
    output logic            xfer_dir,
    output logic [AW-1:0]   xfer_mem_addr,
    output logic [AW-1:0]   xfer_per_addr,
    output logic            irq
);

    ctrl_t            cfg;
    logic [AW-1:0]    mptr, pptr;
    logic [31:0]      mseq, pseq;
    logic             busy, pend, halted, ping;
    logic [CNT_W-1:0] remain;
    logic             ctrl_wr, stat_wr;
    logic [31:0]      stat_word;

    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
    assign stat_wr = reg_we && (reg_addr == A_STAT);

    pdma_regfile #(.AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (cfg),
        .mptr  (mptr),
        .pptr  (pptr),
        .mseq  (mseq),
        .pseq  (pseq)
    );

    pdma_engine #(.AW(AW), .NREQ(NREQ)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg           (cfg),
        .dbl           (mseq[DBL_BIT]),
        .mptr          (mptr),
        .pptr          (pptr),
        .ctrl_wr       (ctrl_wr),
        .new_en        (reg_wdata[31]),
        .new_wcnt      (reg_wdata[2 +: CNT_W]),
        .stat_wr       (stat_wr),
        .stat_clr      (reg_wdata[30]),
        .dreq          (dreq),
        .xfer_ready    (xfer_ready),
        .xfer_valid    (xfer_valid),
        .xfer_dir      (xfer_dir),
        .xfer_mem_addr (xfer_mem_addr),
        .xfer_per_addr (xfer_per_addr),
        .busy          (busy),
        .pend          (pend),
        .halted        (halted),
        .ping          (ping),
        .remain        (remain),
        .irq           (irq)
    );

    assign stat_word = {busy, pend, halted, ping, {PAD_W{1'b0}}, remain, 2'b00};

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = pack_ctrl(cfg);
            A_STAT:  reg_rdata = stat_word;
            A_MPTR:  reg_rdata = 32'(mptr);
            A_MSEQ:  reg_rdata = mseq;
            A_PPTR:  reg_rdata = 32'(pptr);
            A_PSEQ:  reg_rdata = pseq;
            default: reg_rdata = '0;
        endcase
    end

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[30]) |=> !irq);

endmodule

// File: tb/sim_pdma_channel.sv
module sim_pdma_channel;

    localparam int CLK_T = 10;
    localparam int AW    = 32;
    localparam int NREQ  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NREQ-1:0] dreq = '0;
    logic            xfer_ready = 1'b0;
    logic            xfer_valid, xfer_dir, irq;
    logic [AW-1:0]   xfer_mem_addr, xfer_per_addr;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] PBASE = 32'h8000_0040;

    always #(CLK_T/2) clk = ~clk;

    pdma_channel #(.AW(AW), .NREQ(NREQ)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .xfer_ready(xfer_ready), .xfer_valid(xfer_valid), .xfer_dir(xfer_dir),
        .xfer_mem_addr(xfer_mem_addr), .xfer_per_addr(xfer_per_addr), .irq(irq)
    );

    function automatic logic [31:0] mkctrl(bit en, bit ie, bit hold, bit dir, bit once,
                                           bit flow, int rsel, int wcnt);
        logic [31:0] w;
        w = '0;
        w[31] = en; w[30] = ie; w[29] = hold; w[28] = dir; w[27] = once;
        w[21] = flow; w[20:16] = 5'(rsel); w[15:2] = 14'(wcnt);
        return w;
    endfunction

    function automatic logic [31:0] mkstat(bit b, bit p, bit h, bit pp, int rem);
        logic [31:0] w;
        w = '0;
        w[31] = b; w[30] = p; w[29] = h; w[28] = pp; w[15:2] = 14'(rem);
        return w;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic stat_is(string req, string what, logic [31:0] exp);
        logic [31:0] v;
        rd(3'd1, v);
        chk(v == exp, req, what, v, exp);
    endtask

    task automatic clr_pend();
        wr(3'd1, 32'h4000_0000);
    endtask

    // random pacing until n words are accepted; checks gating and addresses
    task automatic run_words(int n, logic [31:0] first, bit dirx, bit flow, int sel, string req);
        int k = 0;
        int guard = 0;
        bit ev;
        while (k < n && guard < 4000) begin
            @(negedge clk);
            xfer_ready = 1'($urandom_range(0, 1));
            dreq = NREQ'($urandom);
            #1;
            ev = !flow || dreq[sel];
            if (xfer_valid !== ev)
                chk(1'b0, "R2", "valid gating", 32'(xfer_valid), 32'(ev));
            if (xfer_valid && xfer_ready) begin
                chk(xfer_mem_addr == first + 32'(4 * k), req, "mem addr",
                    xfer_mem_addr, first + 32'(4 * k));
                if (xfer_per_addr != PBASE || xfer_dir != dirx)
                    chk(1'b0, "R10", "per addr/dir", {xfer_dir, xfer_per_addr[30:0]},
                        {dirx, PBASE[30:0]});
                k++;
            end
            guard++;
        end
        chk(k == n, req, "word count", 32'(k), 32'(n));
        @(negedge clk);
        xfer_ready = 1'b0;
        dreq = '0;
    endtask

    task automatic park_window(string req);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            xfer_ready = 1'b1; dreq = '1;
            #1;
            chk(!xfer_valid, req, "parked valid", 32'(xfer_valid), 32'd0);
        end
        @(negedge clk);
        xfer_ready = 1'b0; dreq = '0;
    endtask

    initial begin
        #(CLK_T * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        stat_is("R1", "status after reset", 32'd0);
        rd(3'd0, v);
        chk(v == 32'd0, "R1", "ctrl after reset", v, 32'd0);
        chk(!irq && !xfer_valid, "R1", "irq/valid after reset", {irq, xfer_valid}, 32'd0);

        // R11 readback
        wr(3'd2, 32'h0000_1003);
        rd(3'd2, v);
        chk(v == 32'h0000_1000, "R11", "mem ptr align", v, 32'h0000_1000);
        wr(3'd5, 32'hA5A5_0003);
        rd(3'd5, v);
        chk(v == 32'hA5A5_0003, "R11", "per seq readback", v, 32'hA5A5_0003);
        wr(3'd4, PBASE);
        rd(3'd4, v);
        chk(v == PBASE, "R11", "per ptr readback", v, PBASE);

        // R3 R4 R7 one-shot with flow control on line 5
        wr(3'd0, mkctrl(1, 1, 0, 0, 1, 1, 5, 6));
        stat_is("R4", "remaining at start", mkstat(1, 0, 0, 0, 6));
        run_words(3, 32'h1000, 0, 1, 5, "R3");
        stat_is("R4", "remaining mid run", mkstat(1, 0, 0, 0, 3));
        run_words(4, 32'h100C, 0, 1, 5, "R3");
        stat_is("R3", "one-shot end", mkstat(0, 1, 0, 0, 6));
        chk(irq == 1'b1, "R7", "irq with ie", 32'(irq), 32'd1);
        park_window("R3");

        // R6 write-one-to-clear
        wr(3'd1, 32'h0000_0000);
        stat_is("R6", "write with bit30 clear", mkstat(0, 1, 0, 0, 6));
        clr_pend();
        stat_is("R6", "write with bit30 set", mkstat(0, 0, 0, 0, 6));
        chk(irq == 1'b0, "R7", "irq after clear", 32'(irq), 32'd0);

        // R7 R10 mem-to-peripheral with interrupts masked, free running
        wr(3'd0, mkctrl(1, 0, 0, 1, 1, 0, 0, 1));
        #1;
        chk(xfer_dir == 1'b1, "R10", "direction bit", 32'(xfer_dir), 32'd1);
        run_words(2, 32'h1000, 1, 0, 0, "R10");
        stat_is("R7", "pend with ie clear", mkstat(0, 1, 0, 0, 1));
        chk(irq == 1'b0, "R7", "irq masked", 32'(irq), 32'd0);
        clr_pend();

        // R6 end of count and clear in the same cycle
        wr(3'd0, mkctrl(1, 0, 0, 0, 1, 0, 0, 0));
        @(negedge clk);
        xfer_ready = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h4000_0000;
        @(negedge clk);
        xfer_ready = 1'b0; reg_we = 1'b0;
        stat_is("R6", "end beats clear", mkstat(0, 1, 0, 0, 0));
        clr_pend();

        // R8 hold and invalid source
        wr(3'd0, mkctrl(1, 0, 1, 0, 1, 0, 0, 3));
        park_window("R8");
        stat_is("R8", "hold status", mkstat(1, 0, 1, 0, 3));
        wr(3'd0, mkctrl(1, 0, 0, 0, 1, 0, 31, 3));
        park_window("R8");
        stat_is("R8", "invalid source status", mkstat(1, 0, 1, 0, 3));
        wr(3'd0, mkctrl(1, 0, 0, 0, 1, 0, 0, 3));
        run_words(4, 32'h1000, 0, 0, 0, "R8");
        stat_is("R8", "resumed run ends", mkstat(0, 1, 0, 0, 3));
        clr_pend();

        // R9 disable mid run
        wr(3'd0, mkctrl(1, 0, 0, 0, 1, 0, 0, 9));
        run_words(2, 32'h1000, 0, 0, 0, "R9");
        wr(3'd0, mkctrl(0, 0, 0, 0, 1, 0, 0, 9));
        park_window("R9");
        rd(3'd1, v);
        chk(v[31] == 1'b0, "R9", "busy after disable", v, 32'd0);

        // R5 continuous double buffer with pointer update mid buffer
        wr(3'd3, 32'h0008_0000);
        wr(3'd0, mkctrl(1, 1, 0, 0, 0, 1, 2, 3));
        run_words(4, 32'h1000, 0, 1, 2, "R5");
        stat_is("R5", "first half", mkstat(1, 1, 0, 1, 3));
        chk(irq == 1'b1, "R5", "irq first half", 32'(irq), 32'd1);
        clr_pend();
        run_words(1, 32'h1010, 0, 1, 2, "R5");
        wr(3'd2, 32'h0000_2000);
        run_words(3, 32'h1014, 0, 1, 2, "R5");
        stat_is("R5", "second half", mkstat(1, 1, 0, 0, 3));
        clr_pend();
        run_words(4, 32'h2000, 0, 1, 2, "R5");
        stat_is("R5", "third half", mkstat(1, 1, 0, 1, 3));
        wr(3'd0, 32'd0);
        clr_pend();

        // R5 continuous without double buffer
        wr(3'd3, 32'h0000_0000);
        wr(3'd0, mkctrl(1, 0, 0, 0, 0, 0, 0, 1));
        run_words(2, 32'h2000, 0, 0, 0, "R5");
        stat_is("R5", "single buffer repeat", mkstat(1, 1, 0, 0, 1));
        run_words(2, 32'h2000, 0, 0, 0, "R5");
        wr(3'd0, 32'd0);
        clr_pend();

        // R3 random one-shot runs
        for (int r = 0; r < 8; r++) begin
            int n = int'($urandom_range(0, 20));
            int sel = int'($urandom_range(0, 30));
            bit fl = 1'($urandom_range(0, 1));
            logic [31:0] base = {16'h0, 14'($urandom), 2'b00};
            wr(3'd2, base);
            wr(3'd0, mkctrl(1, 1, 0, 0, 1, fl, sel, n));
            run_words(n + 1, base, 0, fl, sel, "R3");
            stat_is("R3", "random run end", mkstat(0, 1, 0, 0, n));
            clr_pend();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule